// File: doc/BRIEF.md
# Video Path Source Selector

This block sits in front of a palette DAC and decides, for three independent signal groups, whether the on-board display controller or an external adapter card feeds the shared video path. The groups are the timing group (horizontal sync, vertical sync and blank), the 8-bit pixel address and the dot clock. Each group has its own active-low select input. A select that nobody drives reads as high, so the on-board controller owns the path by default.

All logic runs on a fast system clock `clk`, which oversamples both dot clocks. The rising edge of whichever dot clock is selected captures the selected pixel address and blank level into an output stage. While blank is low, that stage emits a zero colour. When the adapter sources the dot clock, the same clock is also handed to the controller's external clock input, so only one side times the video at a time.

The selects and the 3-bit clock-source field are synchronized into `clk` before use. A legality checker compares them against the allowed combinations and sets a sticky error bit on any violation. While that bit is set, the outputs are held blanked.

Top module: `vidsrc_sel`

## Requirements
- R1: A select whose drive-enable bit is 0 behaves as 1 (on-board source), whatever its value bit holds. Select bit positions are 0 = timing group, 1 = pixel group, 2 = dot-clock group.
- R2: With the effective timing select high, `hsync_o`/`vsync_o` follow the on-board sync inputs; with it low they follow the adapter sync inputs.
- R3: With the effective pixel select high, the captured pixel comes from `int_pix`; with it low, from `adp_pix`.
- R4: `dac_dclk` equals `int_dclk` when the clock select is high and `adp_dclk` when it is low; `ctl_extclk` equals `adp_dclk` when the clock select is low and is 0 otherwise.
- R5: Pixel and blank are captured only on a rising edge of the selected dot clock; edges on the unselected dot clock leave the outputs unchanged.
- R6: When the captured blank (active low, from the selected timing source) is 0, `dac_pix` is 0 and `dac_blank_n` is 0; otherwise `dac_pix` is the captured pixel.
- R7: Adapter dot clock (clock select low) together with on-board pixel data (pixel select high) is illegal and sets `cfg_err`.
- R8: The clock-source field must be 3'b010 when the clock select is low and must differ from 3'b010 when it is high; any violation sets `cfg_err`.
- R9: `cfg_err` is sticky: it stays set until a one-cycle `err_clr` pulse arrives while the configuration is legal, or until reset. If the configuration is still illegal when `err_clr` arrives, the set wins. Reset clears it.
- R10: While `cfg_err` is 1, `dac_blank_n` is 0 and `dac_pix` is 0.
- R11: A change on a select or on the clock-source field reaches the outputs two `clk` rising edges after it is applied, and `cfg_err` reacts one edge later. After reset, `cfg_err`=0, `dac_pix`=0 and `dac_blank_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both dot clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 3 | Active-low group selects (bit0 timing, bit1 pixel, bit2 dot clock) |
| sel_drv | input | 3 | Per-select drive enable; 0 means undriven and pulled high |
| clk_src | input | 3 | Controller clock-source field |
| err_clr | input | 1 | Write-one-to-clear strobe for the error bit |
| int_hsync | input | 1 | On-board horizontal sync |
| int_vsync | input | 1 | On-board vertical sync |
| int_blank_n | input | 1 | On-board blank, active low |
| int_pix | input | 8 | On-board pixel address |
| int_dclk | input | 1 | On-board dot clock |
| adp_hsync | input | 1 | Adapter horizontal sync |
| adp_vsync | input | 1 | Adapter vertical sync |
| adp_blank_n | input | 1 | Adapter blank, active low |
| adp_pix | input | 8 | Adapter pixel address |
| adp_dclk | input | 1 | Adapter dot clock |
| hsync_o | output | 1 | Selected horizontal sync to the display |
| vsync_o | output | 1 | Selected vertical sync to the display |
| dac_dclk | output | 1 | Selected dot clock to the DAC |
| ctl_extclk | output | 1 | Adapter dot clock routed to the controller's external clock input |
| dac_blank_n | output | 1 | Captured blank to the DAC, active low |
| dac_pix | output | 8 | Captured pixel address to the DAC |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions check on every cycle that the error bit only rises after an illegal synchronized configuration and holds until a legal clear, that a set error or a low blank always leaves a zero colour with blank active, and that the controller's external clock input stays quiet unless the adapter owns the clock. The bench scenarios are the only evidence for the rest. They sweep all 64 select and clock-source combinations against an arithmetic legality model, and sweep every pixel value through both the on-board and adapter paths with a changing blank pattern. They also show the pull-up default, that edges on the unselected dot clock are ignored, and the two-edge latency of a select change.

// File: rtl/vsel_pkg.sv
// Package: shared constants and types for the video path source selector.
// Assumes select bit positions are fixed across all sub-blocks.
package vsel_pkg;
    localparam int GRP_SYNC = 0;
    localparam int GRP_PIX  = 1;
    localparam int GRP_CLK  = 2;
    localparam int NUM_GRP  = 3;
    localparam int CSRC_W   = 3;
    localparam logic [CSRC_W-1:0] CSRC_ADAPTER = 3'b010;

    // One timing group bundle: sync lines plus blank.
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic blank_n;
    } tgrp_t;
endpackage

// File: rtl/vsel_sync.sv
// Module: multi-flop synchronizer for a bus of quasi-static controls.
// Assumes each bit is level-stable for many clk cycles (no bus coherency).
module vsel_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: shift the sampled value one flop deeper.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RST_VAL;
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vsel_legal.sv
// Module: legality check of group selects versus clock-source field,
// with a sticky error bit. Assumes inputs are already synchronized.
module vsel_legal
    import vsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_GRP-1:0] grp_adp,   // 1 = adapter owns the group
    input  logic [CSRC_W-1:0] csrc,
    input  logic              err_clr,
    output logic              err
);
    logic clk_from_adp;
    logic csrc_is_adp;
    logic bad_cfg;

    // Purpose: decode the illegal combinations.
    always_comb begin
        clk_from_adp = grp_adp[GRP_CLK];
        csrc_is_adp  = (csrc == CSRC_ADAPTER);
        bad_cfg      = (clk_from_adp && !grp_adp[GRP_PIX])
                     || (clk_from_adp != csrc_is_adp);
    end

    // Purpose: sticky error, set has priority over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (bad_cfg) err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end
endmodule

// File: rtl/vsel_capture.sv
// Module: dot-clock output stage. Detects rising edges of the selected
// dot clock (oversampled by clk) and captures pixel and blank.
// Assumes the dot clock is slower than half the clk rate.
module vsel_capture #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dclk_sel,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             blank_in_n,
    input  logic             force_blank,
    output logic [PIX_W-1:0] pix_out,
    output logic             blank_out_n
);
    logic             dclk_d;
    logic             dot_rise;
    logic [PIX_W-1:0] pix_q;
    logic             blank_q_n;

    assign dot_rise = dclk_sel && !dclk_d;

    // Purpose: remember the previous dot clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_d <= 1'b0;
        else        dclk_d <= dclk_sel;
    end

    // Purpose: capture pixel (zeroed when blanked) and blank on a dot edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q     <= '0;
            blank_q_n <= 1'b0;
        end else if (dot_rise) begin
            pix_q     <= blank_in_n ? pix_in : '0;
            blank_q_n <= blank_in_n;
        end
    end

    // Purpose: an error overrides the captured values with blank.
    always_comb begin
        pix_out     = force_blank ? '0 : pix_q;
        blank_out_n = blank_q_n && !force_blank;
    end
endmodule

// File: rtl/vidsrc_sel.sv
// Module: video path source selector (top). Picks, per group, on-board
// controller or adapter as the source of timing, pixel and dot clock,
// captures into a DAC-facing stage and flags illegal configurations.
// Assumes clk oversamples both dot clocks; selects are quasi-static.
module vidsrc_sel
    import vsel_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel_n,
    input  logic [2:0]        sel_drv,
    input  logic [2:0]        clk_src,
    input  logic              err_clr,
    input  logic              int_hsync,
    input  logic              int_vsync,
    input  logic              int_blank_n,
    input  logic [PIX_W-1:0]  int_pix,
    input  logic              int_dclk,
    input  logic              adp_hsync,
    input  logic              adp_vsync,
    input  logic              adp_blank_n,
    input  logic [PIX_W-1:0]  adp_pix,
    input  logic              adp_dclk,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              dac_dclk,
    output logic              ctl_extclk,
    output logic              dac_blank_n,
    output logic [PIX_W-1:0]  dac_pix,
    output logic              cfg_err
);
    localparam logic [NUM_GRP-1:0] SEL_IDLE = {NUM_GRP{1'b1}};

    logic [NUM_GRP-1:0] sel_eff_n;
    logic [NUM_GRP-1:0] sel_s_n;
    logic [NUM_GRP-1:0] grp_adp;
    logic [CSRC_W-1:0]  clk_src_s;
    tgrp_t              tg_int, tg_adp, tg_sel;
    logic [PIX_W-1:0]   pix_sel;
    logic               dclk_sel;

    // Purpose: an undriven select reads as pulled high.
    assign sel_eff_n = sel_n | ~sel_drv;

    vsel_sync #(.W(NUM_GRP), .STAGES(SYNC_DEPTH), .RST_VAL(SEL_IDLE)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d(sel_eff_n), .q(sel_s_n)
    );

    vsel_sync #(.W(CSRC_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_csrc_sync (
        .clk(clk), .rst_n(rst_n), .d(clk_src), .q(clk_src_s)
    );

    assign grp_adp = ~sel_s_n;

    // Purpose: per-group source multiplexing.
    always_comb begin
        tg_int     = '{hsync: int_hsync, vsync: int_vsync, blank_n: int_blank_n};
        tg_adp     = '{hsync: adp_hsync, vsync: adp_vsync, blank_n: adp_blank_n};
        tg_sel     = grp_adp[GRP_SYNC] ? tg_adp : tg_int;
        pix_sel    = grp_adp[GRP_PIX] ? adp_pix : int_pix;
        dclk_sel   = grp_adp[GRP_CLK] ? adp_dclk : int_dclk;
        ctl_extclk = grp_adp[GRP_CLK] && adp_dclk;
        hsync_o    = tg_sel.hsync;
        vsync_o    = tg_sel.vsync;
        dac_dclk   = dclk_sel;
    end

    vsel_legal u_legal (
        .clk(clk), .rst_n(rst_n), .grp_adp(grp_adp), .csrc(clk_src_s),
        .err_clr(err_clr), .err(cfg_err)
    );

    vsel_capture #(.PIX_W(PIX_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .dclk_sel(dclk_sel), .pix_in(pix_sel),
        .blank_in_n(tg_sel.blank_n), .force_blank(cfg_err),
        .pix_out(dac_pix), .blank_out_n(dac_blank_n)
    );
endmodule

// File: rtl/vsel_chk.sv
// Module: assertion checker for vidsrc_sel, attached through bind.
// Recomputes legality independently from the synchronized controls.
module vsel_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       grp_adp,
    input logic [2:0]       clk_src_s,
    input logic             err_clr,
    input logic             cfg_err,
    input logic             dac_blank_n,
    input logic [PIX_W-1:0] dac_pix,
    input logic             ctl_extclk
);
    logic bad;
    assign bad = (grp_adp[2] & ~grp_adp[1])
               | (grp_adp[2] & (clk_src_s != 3'b010))
               | (~grp_adp[2] & (clk_src_s == 3'b010));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !err_clr) |=> cfg_err);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && err_clr && !bad) |=> !cfg_err);

    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(bad));

    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> cfg_err);

    a_r10_forced: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!dac_blank_n && dac_pix == '0));

    a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_blank_n |-> (dac_pix == '0));

    a_r4_extclk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_adp[2] |-> !ctl_extclk);
endmodule

bind vidsrc_sel vsel_chk #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .grp_adp(grp_adp), .clk_src_s(clk_src_s),
    .err_clr(err_clr), .cfg_err(cfg_err), .dac_blank_n(dac_blank_n),
    .dac_pix(dac_pix), .ctl_extclk(ctl_extclk)
);

// File: tb/sim_vidsrc_sel.sv
module sim_vidsrc_sel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] sel_n = 3'b111, sel_drv = 3'b111, clk_src = 3'b000;
    logic err_clr = 1'b0;
    logic int_hsync = 0, int_vsync = 0, int_blank_n = 1, int_dclk = 0;
    logic adp_hsync = 0, adp_vsync = 0, adp_blank_n = 1, adp_dclk = 0;
    logic [7:0] int_pix = 0, adp_pix = 0;
    logic hsync_o, vsync_o, dac_dclk, ctl_extclk, dac_blank_n, cfg_err;
    logic [7:0] dac_pix;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    vidsrc_sel u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_err();
        err_clr = 1'b1; cyc(1); err_clr = 1'b0; cyc(1);
    endtask

    task automatic pulse_int(); int_dclk = 1; cyc(1); int_dclk = 0; cyc(1); endtask
    task automatic pulse_adp(); adp_dclk = 1; cyc(1); adp_dclk = 0; cyc(1); endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(4);
        // R11 reset state
        chk("R11 reset err", cfg_err, 0);
        chk("R11 reset pix", dac_pix, 0);
        chk("R11 reset blank", dac_blank_n, 0);
        rst_n = 1'b1;
        cyc(4);

        // R7 R8 R9: sweep all select and clock-source combinations
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 8; c++) begin
                bit clka, pixa, ill;
                sel_n = s[2:0]; clk_src = c[2:0];
                cyc(4); clear_err(); cyc(1);
                clka = !s[2]; pixa = !s[1];
                ill = (clka && !pixa) || (clka && c != 2) || (!clka && c == 2);
                chk(ill ? "R7 R8 illegal set" : "R9 legal clears", cfg_err, int'(ill));
            end
        end

        // R10 and R9 stickiness: illegal then back to legal
        sel_n = 3'b011; clk_src = 3'b010; cyc(5);
        chk("R10 err set", cfg_err, 1);
        chk("R10 blank forced", dac_blank_n, 0);
        chk("R10 pix forced", dac_pix, 0);
        sel_n = 3'b111; clk_src = 3'b000; cyc(5);
        chk("R9 sticky", cfg_err, 1);
        clear_err();
        chk("R9 cleared", cfg_err, 0);

        // R1: undriven selects read high even with value bits low
        sel_drv = 3'b000; sel_n = 3'b000; int_hsync = 1; adp_hsync = 0; cyc(5);
        chk("R1 pull-up err", cfg_err, 0);
        chk("R1 pull-up hsync", hsync_o, 1);
        sel_drv = 3'b111; sel_n = 3'b111; cyc(4);

        // R2: timing group sweep
        for (int sel = 0; sel < 2; sel++) begin
            sel_n[0] = sel[0]; cyc(4);
            for (int v = 0; v < 16; v++) begin
                {int_hsync, int_vsync, adp_hsync, adp_vsync} = v[3:0];
                cyc(1);
                chk("R2 hsync", hsync_o, sel ? v[3] : v[1]);
                chk("R2 vsync", vsync_o, sel ? v[2] : v[0]);
            end
        end

        // R11: select latency of two edges
        sel_n[0] = 1'b1; int_hsync = 1; adp_hsync = 0; cyc(4);
        sel_n[0] = 1'b0;
        cyc(1); chk("R11 after one edge", hsync_o, 1);
        cyc(1); chk("R11 after two edges", hsync_o, 0);
        sel_n = 3'b111; cyc(4);

        // R3 R5 R6: on-board pixel sweep
        for (int p = 0; p < 256; p++) begin
            int_pix = p[7:0]; adp_pix = ~p[7:0]; int_blank_n = (p % 5 != 0);
            pulse_int();
            chk("R3 R6 int pix", dac_pix, (p % 5 != 0) ? p : 0);
            chk("R6 int blank", dac_blank_n, int'(p % 5 != 0));
        end
        // R5: unselected edge ignored
        int_blank_n = 1; int_pix = 8'h5A; pulse_int();
        int_pix = 8'hC3; pulse_adp();
        chk("R5 unselected edge", dac_pix, 8'h5A);
        // R4 on-board clock
        int_dclk = 1; adp_dclk = 0; cyc(1);
        chk("R4 dac_dclk int", dac_dclk, 1);
        adp_dclk = 1; cyc(1);
        chk("R4 extclk quiet", ctl_extclk, 0);
        int_dclk = 0; adp_dclk = 0; cyc(2);

        // adapter owns all groups
        sel_n = 3'b000; clk_src = 3'b010; cyc(4); clear_err();
        chk("R8 adapter legal", cfg_err, 0);
        adp_dclk = 1; int_dclk = 0; cyc(1);
        chk("R4 dac_dclk adp", dac_dclk, 1);
        chk("R4 extclk routed", ctl_extclk, 1);
        adp_dclk = 0; cyc(1);
        for (int p = 0; p < 256; p++) begin
            adp_pix = p[7:0]; int_pix = ~p[7:0]; adp_blank_n = (p % 7 != 3);
            int_blank_n = 1;
            pulse_adp();
            chk("R3 R6 adp pix", dac_pix, (p % 7 != 3) ? p : 0);
            chk("R6 adp blank", dac_blank_n, int'(p % 7 != 3));
        end
        adp_blank_n = 1; adp_pix = 8'h33; pulse_adp();
        adp_pix = 8'h44; pulse_int();
        chk("R5 int edge ignored", dac_pix, 8'h33);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule